// File: doc/BRIEF.md
# Two-Bit Branch Predictor with Pipeline Flush

This block supplies direction and target predictions for conditional branches in an in-order pipeline with five or six stages. It holds a small direct-mapped table. Each entry has a two-bit saturating confidence counter and a stored branch target. The table is indexed by the word-address bits of the program counter just above the byte offset. In fetch, the current PC selects an entry, and the block returns a taken/not-taken guess and a target address in the same cycle.

The fetch logic attaches the guess to the instruction, and the guess travels with it until execute. When execute resolves a branch, it presents the branch PC, the carried guess, the real outcome and the computed target. The block then steps that entry's counter toward the real outcome. On a taken outcome it also records the target.

If the carried guess disagrees with the real outcome, the block raises a redirect in that same cycle. The redirect carries the corrected PC, which is the target for a taken branch and the next sequential address for a not-taken one. At the same time the block pulses the kill signals for the decode and execute slots.

Top module: `bp_predictor`

## Requirements
- R1: After reset every counter holds weakly-not-taken (01) and every target holds zero, so any lookup returns pred_taken_o=0 and pred_target_o=0.
- R2: The counter is coded 00 strong-not-taken, 01 weak-not-taken, 10 weak-taken, 11 strong-taken. pred_taken_o is bit 1 of the selected counter, so one taken resolution from reset makes that entry predict taken.
- R3: A taken resolution at 11 leaves the counter at 11. From strong-taken, one not-taken resolution still predicts taken and a second one predicts not-taken.
- R4: A not-taken resolution at 00 leaves the counter at 00. From strong-not-taken, one taken resolution still predicts not-taken.
- R5: A taken resolution writes ex_target_i into the entry's target. A not-taken resolution leaves the stored target unchanged.
- R6: The entry is chosen by PC bits [5:2] (16 entries). Entries with different indices are independent, and PCs that differ only above bit 5 share an entry.
- R7: When a resolution and a lookup address the same entry in the same cycle, the lookup returns the old counter and target. The new values appear from the next cycle.
- R8: redirect_o, flush_dec_o and flush_ex_o are high in exactly the cycles where ex_valid_i is high and ex_pred_taken_i differs from ex_taken_i. With ex_valid_i low, the execute inputs change neither the outputs nor the table.
- R9: During a redirect, redirect_pc_o equals ex_target_i if ex_taken_i is 1 and ex_pc_i+4 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_pc_i | input | 32 | PC being fetched |
| pred_taken_o | output | 1 | Predicted direction for fetch_pc_i |
| pred_target_o | output | 32 | Stored target for fetch_pc_i |
| ex_valid_i | input | 1 | A branch is resolved in execute this cycle |
| ex_pc_i | input | 32 | PC of the resolved branch |
| ex_pred_taken_i | input | 1 | Guess carried with the branch from fetch |
| ex_taken_i | input | 1 | Real branch outcome |
| ex_target_i | input | 32 | Computed branch target |
| redirect_o | output | 1 | Misprediction, load redirect_pc_o into the PC |
| redirect_pc_o | output | 32 | Corrected fetch address |
| flush_dec_o | output | 1 | Kill the instruction in decode |
| flush_ex_o | output | 1 | Kill the instruction in execute |

## Verification
Fetch lookup and execute update can hit the same table entry in one cycle. The bench provokes this by placing a lookup PC and a taken resolution with the same index bits in one cycle. It reads the prediction before the clock edge, where it expects the old weak-not-taken state and a zero target. It reads again after the edge, where it expects taken with the new target. Redirect checks are made in the resolving cycle itself, with the guess both matching and mismatching the outcome.

// File: rtl/bp_pkg.sv
package bp_pkg;
  typedef enum logic [1:0] {
    CTR_SNT = 2'b00,
    CTR_WNT = 2'b01,
    CTR_WT  = 2'b10,
    CTR_ST  = 2'b11
  } ctr_e;

  function automatic ctr_e ctr_step(ctr_e c, logic taken);
    if (taken) return (c == CTR_ST) ? CTR_ST : ctr_e'(c + 2'd1);
    else       return (c == CTR_SNT) ? CTR_SNT : ctr_e'(c - 2'd1);
  endfunction
endpackage

// File: rtl/bp_entry.sv
module bp_entry #(
  parameter int unsigned PC_W = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            upd_i,
  input  logic            taken_i,
  input  logic [PC_W-1:0] target_i,
  output logic            pred_o,
  output logic [PC_W-1:0] target_o
);
  import bp_pkg::*;

  ctr_e            ctr_q;
  logic [PC_W-1:0] tgt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctr_q <= CTR_WNT;
      tgt_q <= '0;
    end else if (upd_i) begin
      ctr_q <= ctr_step(ctr_q, taken_i);
      if (taken_i) tgt_q <= target_i;
    end
  end

  assign pred_o   = ctr_q[1];
  assign target_o = tgt_q;
endmodule

// File: rtl/bp_resolve.sv
module bp_resolve #(
  parameter int unsigned PC_W = 32
) (
  input  logic            valid_i,
  input  logic [PC_W-1:0] pc_i,
  input  logic            pred_taken_i,
  input  logic            taken_i,
  input  logic [PC_W-1:0] target_i,
  output logic            mispred_o,
  output logic [PC_W-1:0] fix_pc_o
);
  assign mispred_o = valid_i && (pred_taken_i != taken_i);
  assign fix_pc_o  = taken_i ? target_i : pc_i + PC_W'(4);
endmodule

// File: rtl/bp_predictor.sv
module bp_predictor #(
  parameter int unsigned PC_W    = 32,
  parameter int unsigned IDX_W   = 4,
  parameter int unsigned IDX_LSB = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PC_W-1:0] fetch_pc_i,
  output logic            pred_taken_o,
  output logic [PC_W-1:0] pred_target_o,
  input  logic            ex_valid_i,
  input  logic [PC_W-1:0] ex_pc_i,
  input  logic            ex_pred_taken_i,
  input  logic            ex_taken_i,
  input  logic [PC_W-1:0] ex_target_i,
  output logic            redirect_o,
  output logic [PC_W-1:0] redirect_pc_o,
  output logic            flush_dec_o,
  output logic            flush_ex_o
);
  localparam int unsigned ENTRIES = 1 << IDX_W;
  localparam int unsigned IDX_MSB = IDX_LSB + IDX_W - 1;

  logic [IDX_W-1:0] rd_idx, wr_idx;
  logic [ENTRIES-1:0] pred_vec;
  logic [PC_W-1:0] tgt_vec [ENTRIES];

  assign rd_idx = fetch_pc_i[IDX_MSB:IDX_LSB];
  assign wr_idx = ex_pc_i[IDX_MSB:IDX_LSB];

  logic unused_fetch_bits;
  assign unused_fetch_bits = ^{fetch_pc_i[PC_W-1:IDX_MSB+1], fetch_pc_i[IDX_LSB-1:0]};

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    bp_entry #(.PC_W(PC_W)) u_ent (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .upd_i    (ex_valid_i && (wr_idx == IDX_W'(g))),
      .taken_i  (ex_taken_i),
      .target_i (ex_target_i),
      .pred_o   (pred_vec[g]),
      .target_o (tgt_vec[g])
    );
  end

  // entries update at the edge, so a same-cycle read sees the old value
  assign pred_taken_o  = pred_vec[rd_idx];
  assign pred_target_o = tgt_vec[rd_idx];

  logic mispred;
  bp_resolve #(.PC_W(PC_W)) u_res (
    .valid_i      (ex_valid_i),
    .pc_i         (ex_pc_i),
    .pred_taken_i (ex_pred_taken_i),
    .taken_i      (ex_taken_i),
    .target_i     (ex_target_i),
    .mispred_o    (mispred),
    .fix_pc_o     (redirect_pc_o)
  );

  assign redirect_o  = mispred;
  assign flush_dec_o = mispred;
  assign flush_ex_o  = mispred;
endmodule

// File: rtl/bp_predictor_chk.sv
module bp_predictor_chk #(
  parameter int unsigned PC_W = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [PC_W-1:0] fetch_pc_i,
  input logic            pred_taken_o,
  input logic [PC_W-1:0] pred_target_o,
  input logic            ex_valid_i,
  input logic [PC_W-1:0] ex_pc_i,
  input logic            ex_pred_taken_i,
  input logic            ex_taken_i,
  input logic [PC_W-1:0] ex_target_i,
  input logic            redirect_o,
  input logic [PC_W-1:0] redirect_pc_o,
  input logic            flush_dec_o,
  input logic            flush_ex_o
);
  a_r8_redirect_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o |-> ex_valid_i && (ex_pred_taken_i != ex_taken_i));

  a_r8_redirect_needed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ex_valid_i && (ex_pred_taken_i != ex_taken_i)) |-> redirect_o);

  a_r8_flush_pair: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o |-> flush_dec_o && flush_ex_o);

  a_r8_no_stray_flush: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ex_valid_i |-> !flush_dec_o && !flush_ex_o);

  a_r9_taken_pc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (redirect_o && ex_taken_i) |-> redirect_pc_o == ex_target_i);

  a_r9_fallthru_pc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (redirect_o && !ex_taken_i) |-> redirect_pc_o == ex_pc_i + PC_W'(4));

  a_r7_quiet_table: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(!ex_valid_i) && $stable(fetch_pc_i)) |-> ($stable(pred_taken_o) && $stable(pred_target_o)));
endmodule

bind bp_predictor bp_predictor_chk #(.PC_W(PC_W)) u_chk (.*);

// File: tb/sim_bp_predictor.sv
module sim_bp_predictor;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] fetch_pc = '0;
  logic        pred_taken;
  logic [31:0] pred_target;
  logic        ex_valid = 1'b0;
  logic [31:0] ex_pc = '0;
  logic        ex_pred = 1'b0;
  logic        ex_taken = 1'b0;
  logic [31:0] ex_target = '0;
  logic        redirect;
  logic [31:0] redirect_pc;
  logic        flush_dec, flush_ex;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  bp_predictor u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .fetch_pc_i(fetch_pc), .pred_taken_o(pred_taken), .pred_target_o(pred_target),
    .ex_valid_i(ex_valid), .ex_pc_i(ex_pc), .ex_pred_taken_i(ex_pred),
    .ex_taken_i(ex_taken), .ex_target_i(ex_target),
    .redirect_o(redirect), .redirect_pc_o(redirect_pc),
    .flush_dec_o(flush_dec), .flush_ex_o(flush_ex)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic look(input logic [31:0] pc, input logic exp_t,
                      input logic [31:0] exp_tgt, input string req);
    @(negedge clk);
    fetch_pc = pc;
    #1;
    chk(req, {31'b0, pred_taken}, {31'b0, exp_t});
    chk(req, pred_target, exp_tgt);
  endtask

  // one resolution; checks redirect outputs within the resolving cycle
  task automatic resolve(input logic [31:0] pc, input logic pred, input logic tk,
                         input logic [31:0] tgt);
    logic [31:0] fix;
    logic        mis;
    @(negedge clk);
    ex_valid = 1'b1; ex_pc = pc; ex_pred = pred; ex_taken = tk; ex_target = tgt;
    mis = (pred != tk);
    fix = tk ? tgt : pc + 32'd4;
    #1;
    chk("R8 redirect", {31'b0, redirect}, {31'b0, mis});
    chk("R8 flush", {30'b0, flush_dec, flush_ex}, {30'b0, mis, mis});
    if (mis) chk("R9 fix pc", redirect_pc, fix);
    @(posedge clk);
    #1;
    ex_valid = 1'b0;
  endtask

  task automatic t_reset;
    look(32'h0000_0000, 1'b0, 32'h0, "R1 reset");
    look(32'h0000_003C, 1'b0, 32'h0, "R1 reset");
    look(32'hFFFF_FF18, 1'b0, 32'h0, "R1 reset");
  endtask

  task automatic t_train;
    resolve(32'h100, 1'b0, 1'b1, 32'h800);
    look(32'h100, 1'b1, 32'h800, "R2 R5 trained");
  endtask

  task automatic t_sat_high;
    for (int i = 0; i < 3; i++) resolve(32'h100, 1'b1, 1'b1, 32'h800);
    resolve(32'h100, 1'b1, 1'b0, 32'h444);
    look(32'h100, 1'b1, 32'h800, "R3 R5 one down from strong");
    resolve(32'h100, 1'b1, 1'b0, 32'h444);
    look(32'h100, 1'b0, 32'h800, "R3 two down");
  endtask

  task automatic t_sat_low;
    for (int i = 0; i < 3; i++) resolve(32'h208, 1'b0, 1'b0, 32'h0);
    resolve(32'h208, 1'b0, 1'b1, 32'hA00);
    look(32'h208, 1'b0, 32'hA00, "R4 one up from strong-nt");
  endtask

  task automatic t_index;
    look(32'h10C, 1'b0, 32'h0, "R6 untouched entry");
    look(32'h140, 1'b0, 32'h800, "R6 alias above bit 5");
    resolve(32'h3040, 1'b0, 1'b1, 32'hC00);
    look(32'h100, 1'b1, 32'hC00, "R6 alias write");
    look(32'h208, 1'b0, 32'hA00, "R6 other entry kept");
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    fetch_pc = 32'h114;
    ex_valid = 1'b1; ex_pc = 32'h114; ex_pred = 1'b0; ex_taken = 1'b1; ex_target = 32'h900;
    #1;
    chk("R7 old counter", {31'b0, pred_taken}, 32'h0);
    chk("R7 old target", pred_target, 32'h0);
    chk("R8 R9 same cycle", redirect_pc, 32'h900);
    @(posedge clk);
    #1;
    ex_valid = 1'b0;
    chk("R7 new counter", {31'b0, pred_taken}, 32'h1);
    chk("R7 new target", pred_target, 32'h900);
  endtask

  task automatic t_idle;
    @(negedge clk);
    fetch_pc = 32'h118;
    ex_valid = 1'b0; ex_pc = 32'h118; ex_pred = 1'b0; ex_taken = 1'b1; ex_target = 32'h777;
    #1;
    chk("R8 idle no redirect", {29'b0, redirect, flush_dec, flush_ex}, 32'h0);
    @(posedge clk);
    @(posedge clk);
    #1;
    chk("R8 idle table kept", {31'b0, pred_taken}, 32'h0);
    chk("R8 idle target kept", pred_target, 32'h0);
  endtask

  initial begin
    #12;
    rst_n = 1'b1;
    t_reset();
    t_train();
    t_sat_high();
    t_sat_low();
    t_index();
    t_same_cycle();
    t_idle();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #100000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule